// File: doc/BRIEF.md
# UART Bit-Rate Tick Generator

This block derives the bit-timing strobes of a UART from the system clock. No derived clocks are produced. The division is split across two stages. The first is a power-of-two prescaler whose exponent comes from a 4-bit select value. It yields a "basic" enable every 2^select system cycles. The second stage counts basic enables up to a programmable 8-bit count. Its terminal events alternate between a half-bit strobe and a full-bit strobe. In effect, the count divider's output is divided by two once more, so a bit lasts 2^select × 2 × count system cycles.

The select and count values are loaded through two write strobes. Out-of-range values are clamped: select is limited to at most 11, and count to at least 8. Any write, and any cycle with the enable input low, restarts both stages from zero and drops `ready`. After a restart, `ready` rises once two basic periods have elapsed. Only then does the divider run, so the transmitter and receiver have a settled rate before the first strobe. The half-bit strobe marks the middle of each bit period and is intended for receiver sampling.

Top module: `uart_rate_gen`

## Requirements
- R1: Reset state. While reset is asserted, `ready`, `bit_tick` and `half_tick` are 0. Select resets to 0 and count resets to 8. After reset is released with `en` high, the block behaves as if it had just been restarted with select 0 and count 8.
- R2: Prescaler period. Take the first cycle after a restart as cycle 0, and let P = 2^select. Basic enables occur in cycles P-1, 2P-1 and so on. `ready` is first 1 in cycle 2P, which is two basic periods after the restart.
- R3: Bit period. With count C, the first `bit_tick` is in cycle (2+2C)·P-1. Each later `bit_tick` follows the previous one by exactly 2·C·P cycles.
- R4: Half-bit strobe. The first `half_tick` is in cycle (2+C)·P-1. Each bit period contains exactly one `half_tick`, placed C·P cycles after the start of the bit. The two strobes are never high in the same cycle.
- R5: A count written below 8 is stored as 8.
- R6: A select written above 11 is stored as 11.
- R7: Writing select (`wr_sel`) or count (`wr_cnt`) restarts both stages from zero. It forces `ready` to 0 in the next cycle, and the timing of R2 to R4 then applies from the cycle after the write edge.
- R8: While `en` is 0, `ready`, `bit_tick` and `half_tick` stay 0 and all counters are held at zero. The first cycle with `en` high counts as cycle 0 of a restart.
- R9: Each strobe is a pulse one system cycle wide. Strobes occur only while `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds the generator cleared |
| wr_sel | input | 1 | Load strobe for the prescaler select |
| sel_wdata | input | 4 | Prescaler exponent to load (clamped to 11) |
| wr_cnt | input | 1 | Load strobe for the divider count |
| cnt_wdata | input | 8 | Divider count to load (clamped to at least 8) |
| ready | output | 1 | High once the rate has settled after a restart |
| bit_tick | output | 1 | One-cycle strobe at the end of each bit period |
| half_tick | output | 1 | One-cycle strobe at the middle of each bit period |

## Verification
The embedded assertions check properties that hold on every cycle:
- the stored select and count stay inside their clamped ranges;
- the divider count stays below the stored count;
- strobes are single-cycle, never coincide, and appear only when `ready` is high;
- a write or a low `en` drops `ready` on the next cycle.

The exact cycle positions can only be shown by the directed scenarios, which count cycles from each restart. These positions are the rise of `ready`, the first half and full strobes, and the bit period. The scenarios cover several select and count pairs, the clamping of both fields, mid-run reconfiguration and re-enable.

// File: rtl/uart_rate_gen.sv
module uart_rate_gen #(
  parameter int SEL_W   = 4,
  parameter int MAX_SEL = 11,
  parameter int CNT_W   = 8,
  parameter int MIN_CNT = 8,
  parameter int SETTLE  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr_sel,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic             ready,
  output logic             bit_tick,
  output logic             half_tick
);
  localparam int PRE_W = (MAX_SEL > 0) ? MAX_SEL : 1;
  localparam int ST_W  = $clog2(SETTLE + 1);

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] div_q;
  logic             phase_q;
  logic [ST_W-1:0]  settle_q;
  logic             ready_q;

  wire restart = wr_sel | wr_cnt | ~en;

  wire [SEL_W-1:0] sel_clamp = (sel_wdata > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel_wdata;
  wire [CNT_W-1:0] cnt_clamp = (cnt_wdata < CNT_W'(MIN_CNT)) ? CNT_W'(MIN_CNT) : cnt_wdata;

  wire [PRE_W-1:0] pre_mask = ~({PRE_W{1'b1}} << sel_q);
  wire basic   = en & (pre_q == pre_mask);
  wire div_end = ready_q & basic & (div_q == cnt_q - CNT_W'(1));

  assign half_tick = div_end & ~phase_q;
  assign bit_tick  = div_end & phase_q;
  assign ready     = ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= CNT_W'(MIN_CNT);
    end else begin
      if (wr_sel) sel_q <= sel_clamp;
      if (wr_cnt) cnt_q <= cnt_clamp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pre_q    <= '0;
      div_q    <= '0;
      phase_q  <= 1'b0;
      settle_q <= ST_W'(SETTLE);
      ready_q  <= 1'b0;
    end else begin
      pre_q <= basic ? '0 : pre_q + PRE_W'(1);
      if (!ready_q) begin
        if (basic) begin
          if (settle_q == ST_W'(1)) ready_q <= 1'b1;
          settle_q <= settle_q - ST_W'(1);
        end
      end else if (basic) begin
        if (div_end) begin
          div_q   <= '0;
          phase_q <= ~phase_q;
        end else begin
          div_q <= div_q + CNT_W'(1);
        end
      end
    end
  end

  AST_SEL_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q <= SEL_W'(MAX_SEL)); // R6
  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q >= CNT_W'(MIN_CNT)); // R5
  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    div_q < cnt_q); // R3
  AST_NO_COINCIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_tick && half_tick)); // R4
  AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick); // R9
  AST_HALF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> !half_tick); // R9
  AST_TICK_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick || half_tick) |-> ready); // R9
  AST_WR_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel || wr_cnt) |=> !ready); // R7
  AST_EN_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!ready && !bit_tick && !half_tick)); // R8
endmodule

// File: tb/uart_rate_gen_test.sv
module uart_rate_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic       wr_sel = 1'b0;
  logic [3:0] sel_wdata = '0;
  logic       wr_cnt = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic       ready, bit_tick, half_tick;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  uart_rate_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .wr_sel(wr_sel), .sel_wdata(sel_wdata),
    .wr_cnt(wr_cnt), .cnt_wdata(cnt_wdata),
    .ready(ready), .bit_tick(bit_tick), .half_tick(half_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      check(1'b0, "watchdog", cycles, 190000);
      finish_run();
    end
  end

  // Caller stands at the negedge of cycle index off (0 after a write).
  task automatic measure(input string tag, input int p, input int c, input int off);
    int e_rdy = 2*p - off;
    int e_h1  = (2+c)*p - 1 - off;
    int e_b1  = (2+2*c)*p - 1 - off;
    int e_b2  = e_b1 + 2*c*p;
    int e_h2  = e_h1 + 2*c*p;
    int rdy = -1, h1 = -1, h2 = -1, b1 = -1, b2 = -1;
    int clash = 0, dbl = 0, early = 0;
    bit prev_b = 1'b0;
    for (int k = 0; k <= e_b2 + 3; k++) begin
      if (ready && rdy < 0) rdy = k;
      if ((bit_tick || half_tick) && !ready) early++;
      if (bit_tick && half_tick) clash++;
      if (bit_tick && prev_b) dbl++;
      prev_b = bit_tick;
      if (half_tick) begin
        if (h1 < 0) h1 = k; else if (h2 < 0) h2 = k;
      end
      if (bit_tick) begin
        if (b1 < 0) b1 = k; else if (b2 < 0) b2 = k;
      end
      @(negedge clk);
    end
    check(rdy == e_rdy, {"R2 ready rise ", tag}, rdy, e_rdy);
    check(h1 == e_h1, {"R4 first half ", tag}, h1, e_h1);
    check(b1 == e_b1, {"R3 first bit ", tag}, b1, e_b1);
    check(b2 - b1 == 2*c*p, {"R3 bit period ", tag}, b2 - b1, 2*c*p);
    check(h2 == e_h2, {"R4 second half ", tag}, h2, e_h2);
    check(clash == 0 && dbl == 0 && early == 0, {"R9 pulse shape ", tag},
          clash + dbl + early, 0);
  endtask

  task automatic write_cfg(input bit ws, input int s, input bit wc, input int c);
    @(negedge clk);
    wr_sel = ws; sel_wdata = 4'(s);
    wr_cnt = wc; cnt_wdata = 8'(c);
    @(negedge clk);
    wr_sel = 1'b0; wr_cnt = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(!ready && !bit_tick && !half_tick, "R1 outputs in reset",
          {ready, bit_tick, half_tick}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    measure("R1 defaults", 1, 8, 1);
  endtask

  task automatic t_basic();
    write_cfg(1, 0, 1, 8);
    measure("sel0 cnt8", 1, 8, 0);
  endtask

  task automatic t_sel3();
    write_cfg(1, 3, 1, 10);
    measure("sel3 cnt10", 8, 10, 0);
  endtask

  task automatic t_cnt_max();
    write_cfg(1, 0, 1, 255);
    measure("sel0 cnt255", 1, 255, 0);
  endtask

  task automatic t_cnt_clamp();
    write_cfg(1, 1, 1, 3);
    measure("R5 cnt3 clamped", 2, 8, 0);
  endtask

  task automatic t_sel_clamp();
    write_cfg(1, 15, 1, 8);
    measure("R6 sel15 clamped", 2048, 8, 0);
  endtask

  task automatic t_restart();
    write_cfg(1, 2, 1, 9);
    repeat (100) @(negedge clk);
    write_cfg(0, 0, 1, 12);
    measure("R7 cnt write mid-run", 4, 12, 0);
    repeat (37) @(negedge clk);
    write_cfg(1, 1, 0, 0);
    measure("R7 sel write mid-run", 2, 12, 0);
  endtask

  task automatic t_enable();
    int seen = 0;
    write_cfg(1, 2, 1, 8);
    repeat (60) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 80; k++) begin
      if (ready || bit_tick || half_tick) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R8 quiet while disabled", seen, 0);
    en = 1'b1;
    @(negedge clk);
    measure("R8 re-enable", 4, 8, 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_sel3();
    t_cnt_max();
    t_cnt_clamp();
    t_restart();
    t_enable();
    t_sel_clamp();
    finish_run();
  end
endmodule